// File: doc/BRIEF.md
# Synchronizer PLL Mode Controller

This block decides the operating mode of the core loop in a network timing synchronizer. A processor or a pair of strap pins asks for a mode with a two-bit code. The block weighs that request against the health of the chosen timing reference and then settles the active mode. The possible modes are tracking (Normal), processor-requested Holdover, Freerun, and a hidden automatic holdover.

While the loop tracks a healthy reference and reports lock, the block keeps a copy of the loop's frequency-control word. In either holdover state it drives that stored word to the numerically controlled oscillator, so the output frequency stays where it was. In Freerun it drives a fixed nominal word.

When the selected reference fails, the block drops from Normal into automatic holdover without help from the processor. A reference has failed when its signal is lost or it has drifted too far. When the reference recovers, the block returns to Normal on its own. Both holdover states are reported as a single holdover status. The block refuses to enter Normal when the selected reference is unusable.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After reset the active mode is Freerun (`mode_o` = 10), `holdover_o`, `lock_o` and `status_o` are zero, and `nco_word_o` equals the NOMINAL parameter.
- R2: Request codes on `mode_req_i` are 00 Normal, 01 Holdover, 10 Freerun and 11 keep the current mode. Active mode codes on `mode_o` are 00 Normal, 01 Holdover (manual or automatic) and 10 Freerun. A granted request is visible after the next rising clock edge.
- R3: In Normal, if the selected reference is failed and the request is 00 or 11, the next edge moves the block to automatic holdover, with `mode_o` = 01 and `holdover_o` = 1.
- R4: In automatic holdover, with a request of 00 or 11 and a healthy selected reference, the next edge returns the block to Normal.
- R5: A request for Normal from Holdover or Freerun is refused while the selected reference is failed, and the mode is unchanged. A `ref_sel_i` value of NUM_REF or above counts as failed.
- R6: The stored coefficient starts at NOMINAL. It loads `loop_word_i` on an edge only when the block is in Normal, `upd_tick_i` and `pll_lock_i` are high, and the selected reference is healthy. It is never loaded on a cycle in which the selected reference is failed.
- R7: `nco_word_o` follows `loop_word_i` in Normal in the same cycle. It equals the stored coefficient in either holdover state and equals NOMINAL in Freerun.
- R8: `status_o` carries the holdover status on bit 4 and the lock status on bit 0. All other bits are zero.
- R9: `lock_o` is the registered value of `pll_lock_i` when the next mode is Normal, and is 0 in every other mode.
- R10: In Normal, changing `ref_sel_i` to a failed reference moves the block to automatic holdover on the next edge.
- R11: In Normal, a Holdover or Freerun request wins over a reference failure in the same cycle. A manual Holdover entered this way does not return to Normal on recovery while the request is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 2 | Requested mode code |
| ref_sel_i | input | SELW | Index of the selected reference |
| ref_fail_i | input | NUM_REF | Per-reference failure flag (loss or excess drift) |
| pll_lock_i | input | 1 | Lock indication from the core loop |
| upd_tick_i | input | 1 | Coefficient update strobe |
| loop_word_i | input | W | Frequency-control word from the loop filter |
| mode_o | output | 2 | Active mode code |
| nco_word_o | output | W | Frequency-control word to the oscillator |
| holdover_o | output | 1 | Holdover status (manual or automatic) |
| lock_o | output | 1 | Lock status |
| status_o | output | STAT_W | Status register image |

## Verification
Two events can land in the same cycle. One is a reference failure while in Normal with a manual Holdover or Freerun request. The other is a failure arriving on the cycle of a coefficient update tick. The bench drives both on purpose. The expected results are that the manual request wins and that the coefficient keeps its earlier value. A behavioural model, compared with the outputs on every cycle, judges both. Directed checks tell automatic holdover apart from manual holdover by later recovery with request 11, because the two share one status code.

// File: rtl/pll_mode_pkg.sv
`timescale 1ns/1ps
package pll_mode_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'b00,
      ST_HOLD   = 2'b01,
      ST_FREE   = 2'b10,
      ST_AUTO   = 2'b11
   } pll_state_e;

   localparam logic [1:0] REQ_NORMAL = 2'b00;
   localparam logic [1:0] REQ_HOLD   = 2'b01;
   localparam logic [1:0] REQ_FREE   = 2'b10;
   localparam logic [1:0] REQ_KEEP   = 2'b11;

   localparam logic [1:0] CODE_NORMAL = 2'b00;
   localparam logic [1:0] CODE_HOLD   = 2'b01;
   localparam logic [1:0] CODE_FREE   = 2'b10;

   function automatic logic [1:0] mode_code(pll_state_e s);
      case (s)
         ST_NORMAL: return CODE_NORMAL;
         ST_FREE:   return CODE_FREE;
         default:   return CODE_HOLD;
      endcase
   endfunction

   function automatic logic is_holdover(pll_state_e s);
      return (s == ST_HOLD) || (s == ST_AUTO);
   endfunction
endpackage

// File: rtl/pll_ref_health.sv
`timescale 1ns/1ps
module pll_ref_health #(
   parameter int NUM_REF = 2,
   parameter int SELW    = 1
) (
   input  logic [SELW-1:0]    ref_sel_i,
   input  logic [NUM_REF-1:0] ref_fail_i,
   output logic               sel_ok_o
);
   generate
      if (NUM_REF < 1) begin : g_bad_count
         $error("pll_ref_health: NUM_REF must be at least 1");
      end
      if (NUM_REF == 1) begin : g_single
         assign sel_ok_o = ~ref_fail_i[0] & (ref_sel_i == '0);
      end else begin : g_multi
         logic [NUM_REF-1:0] healthy;
         for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
            assign healthy[g] = ~ref_fail_i[g];
         end
         always_comb begin
            sel_ok_o = 1'b0;
            for (int i = 0; i < NUM_REF; i++) begin
               if (ref_sel_i == SELW'(i)) sel_ok_o = healthy[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pll_mode_fsm.sv
`timescale 1ns/1ps
module pll_mode_fsm
   import pll_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_req_i,
   input  logic       sel_ok_i,
   input  logic       pll_lock_i,
   output pll_state_e state_o,
   output logic [1:0] mode_o,
   output logic       holdover_o,
   output logic       lock_o
);
   pll_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_NORMAL: begin
            if (mode_req_i == REQ_HOLD)      state_d = ST_HOLD;
            else if (mode_req_i == REQ_FREE) state_d = ST_FREE;
            else if (!sel_ok_i)              state_d = ST_AUTO;
         end
         ST_HOLD, ST_FREE: begin
            if (mode_req_i == REQ_HOLD)      state_d = ST_HOLD;
            else if (mode_req_i == REQ_FREE) state_d = ST_FREE;
            else if (mode_req_i == REQ_NORMAL && sel_ok_i) state_d = ST_NORMAL;
         end
         default: begin
            if (mode_req_i == REQ_HOLD)      state_d = ST_HOLD;
            else if (mode_req_i == REQ_FREE) state_d = ST_FREE;
            else if (sel_ok_i)               state_d = ST_NORMAL;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_FREE;
         mode_o     <= CODE_FREE;
         holdover_o <= 1'b0;
         lock_o     <= 1'b0;
      end else begin
         state_q    <= state_d;
         mode_o     <= mode_code(state_d);
         holdover_o <= is_holdover(state_d);
         lock_o     <= pll_lock_i && (state_d == ST_NORMAL);
      end
   end

   assign state_o = state_q;

   p_auto_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NORMAL && mode_req_i[1] == mode_req_i[0] && !sel_ok_i)
      |=> (state_q == ST_AUTO && holdover_o));

   p_auto_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AUTO && mode_req_i[1] == mode_req_i[0] && sel_ok_i)
      |=> (mode_o == CODE_NORMAL));

   p_guard_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_HOLD || state_q == ST_FREE) && !sel_ok_i)
      |=> (mode_o != CODE_NORMAL));

   p_manual_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NORMAL && mode_req_i == REQ_FREE) |=> (mode_o == CODE_FREE));
endmodule

// File: rtl/pll_coef_store.sv
`timescale 1ns/1ps
module pll_coef_store #(
   parameter int              W       = 32,
   parameter logic [W-1:0]    NOMINAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_normal_i,
   input  logic         upd_tick_i,
   input  logic         pll_lock_i,
   input  logic         sel_ok_i,
   input  logic [W-1:0] loop_word_i,
   output logic [W-1:0] coef_o
);
   logic         cap_en;
   logic [W-1:0] coef_q;

   assign cap_en = in_normal_i & upd_tick_i & pll_lock_i & sel_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      coef_q <= NOMINAL;
      else if (cap_en) coef_q <= loop_word_i;
   end

   assign coef_o = coef_q;

   p_freeze_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok_i || !in_normal_i) |=> $stable(coef_q));
endmodule

// File: rtl/pll_word_mux.sv
`timescale 1ns/1ps
module pll_word_mux
   import pll_mode_pkg::*;
#(
   parameter int           W       = 32,
   parameter logic [W-1:0] NOMINAL = '0
) (
   input  pll_state_e   state_i,
   input  logic [W-1:0] loop_word_i,
   input  logic [W-1:0] coef_i,
   output logic [W-1:0] nco_word_o
);
   always_comb begin
      case (state_i)
         ST_NORMAL:       nco_word_o = loop_word_i;
         ST_HOLD, ST_AUTO: nco_word_o = coef_i;
         default:         nco_word_o = NOMINAL;
      endcase
   end
endmodule

// File: rtl/pll_mode_ctrl.sv
`timescale 1ns/1ps
module pll_mode_ctrl
   import pll_mode_pkg::*;
#(
   parameter int           NUM_REF = 2,
   parameter int           W       = 32,
   parameter int           STAT_W  = 8,
   parameter logic [W-1:0] NOMINAL = 32'h4000_0000,
   localparam int          SELW    = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_req_i,
   input  logic [SELW-1:0]    ref_sel_i,
   input  logic [NUM_REF-1:0] ref_fail_i,
   input  logic               pll_lock_i,
   input  logic               upd_tick_i,
   input  logic [W-1:0]       loop_word_i,
   output logic [1:0]         mode_o,
   output logic [W-1:0]       nco_word_o,
   output logic               holdover_o,
   output logic               lock_o,
   output logic [STAT_W-1:0]  status_o
);
   localparam int HOLD_BIT = 4;
   localparam int LOCK_BIT = 0;

   generate
      if (STAT_W <= HOLD_BIT) begin : g_bad_stat
         $error("pll_mode_ctrl: STAT_W must exceed the holdover bit index");
      end
      if (W < 2) begin : g_bad_w
         $error("pll_mode_ctrl: W must be at least 2");
      end
   endgenerate

   logic         sel_ok;
   pll_state_e   state;
   logic [W-1:0] coef;

   pll_ref_health #(.NUM_REF(NUM_REF), .SELW(SELW)) u_health (
      .ref_sel_i  (ref_sel_i),
      .ref_fail_i (ref_fail_i),
      .sel_ok_o   (sel_ok)
   );

   pll_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_req_i (mode_req_i),
      .sel_ok_i   (sel_ok),
      .pll_lock_i (pll_lock_i),
      .state_o    (state),
      .mode_o     (mode_o),
      .holdover_o (holdover_o),
      .lock_o     (lock_o)
   );

   pll_coef_store #(.W(W), .NOMINAL(NOMINAL)) u_coef (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_normal_i (state == ST_NORMAL),
      .upd_tick_i  (upd_tick_i),
      .pll_lock_i  (pll_lock_i),
      .sel_ok_i    (sel_ok),
      .loop_word_i (loop_word_i),
      .coef_o      (coef)
   );

   pll_word_mux #(.W(W), .NOMINAL(NOMINAL)) u_mux (
      .state_i     (state),
      .loop_word_i (loop_word_i),
      .coef_i      (coef),
      .nco_word_o  (nco_word_o)
   );

   always_comb begin
      status_o           = '0;
      status_o[HOLD_BIT] = holdover_o;
      status_o[LOCK_BIT] = lock_o;
   end

   p_lock_only_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> (mode_o == CODE_NORMAL));

   p_free_nominal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == CODE_FREE) |-> (nco_word_o == NOMINAL));

   p_hold_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      holdover_o |-> (mode_o == CODE_HOLD));
endmodule

// File: tb/tb_pll_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pll_mode_ctrl;
   localparam int           NUM_REF = 2;
   localparam int           W       = 32;
   localparam logic [W-1:0] NOM     = 32'h4000_0000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode_req = 2'b11;
   logic [0:0]   ref_sel = 1'b0;
   logic [1:0]   ref_fail = 2'b00;
   logic         pll_lock = 1'b0;
   logic         upd_tick = 1'b0;
   logic [W-1:0] loop_word = '0;
   logic [1:0]   mode_o;
   logic [W-1:0] nco_o;
   logic         hold_o, lock_o;
   logic [7:0]   stat_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pll_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mode_req_i(mode_req), .ref_sel_i(ref_sel),
      .ref_fail_i(ref_fail), .pll_lock_i(pll_lock), .upd_tick_i(upd_tick),
      .loop_word_i(loop_word), .mode_o(mode_o), .nco_word_o(nco_o),
      .holdover_o(hold_o), .lock_o(lock_o), .status_o(stat_o)
   );

   // Behavioural model: 0 normal, 1 manual hold, 2 freerun, 3 auto hold
   int           m_st;
   logic [W-1:0] m_coef;
   logic         m_lock;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 2; m_coef = NOM; m_lock = 0;
      end else begin
         bit ok;
         int nx;
         ok = !ref_fail[ref_sel];
         nx = m_st;
         if (mode_req == 2'b01)      nx = 1;
         else if (mode_req == 2'b10) nx = 2;
         else if (m_st == 0)         nx = ok ? 0 : 3;
         else if (m_st == 3)         nx = ok ? 0 : 3;
         else if (mode_req == 2'b00 && ok) nx = 0;
         if (m_st == 0 && upd_tick && pll_lock && ok) m_coef = loop_word;
         m_st = nx;
         m_lock = pll_lock && (nx == 0);
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [1:0]   em;
      logic [W-1:0] ew;
      logic         eh;
      em = (m_st == 0) ? 2'b00 : (m_st == 2) ? 2'b10 : 2'b01;
      eh = (m_st == 1) || (m_st == 3);
      ew = (m_st == 0) ? loop_word : (m_st == 2) ? NOM : m_coef;
      chk("R2 mode", 64'(mode_o), 64'(em));
      chk("R3 holdover", 64'(hold_o), 64'(eh));
      chk("R7 nco word", 64'(nco_o), 64'(ew));
      chk("R9 lock", 64'(lock_o), 64'(m_lock));
      chk("R8 status", 64'(stat_o), 64'({3'b000, eh, 3'b000, m_lock}));
   endtask

   task automatic drive(logic [1:0] rq, logic sl, logic [1:0] fl, logic lk, logic tk,
                        logic [W-1:0] lw);
      mode_req = rq; ref_sel = sl; ref_fail = fl; pll_lock = lk; upd_tick = tk; loop_word = lw;
   endtask

   task automatic settle();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 mode", 64'(mode_o), 64'(2'b10));
      chk("R1 holdover", 64'(hold_o), 64'd0);
      chk("R1 lock", 64'(lock_o), 64'd0);
      chk("R1 status", 64'(stat_o), 64'd0);
      chk("R1 nco", 64'(nco_o), 64'(NOM));
      rst_n = 1'b1;
      settle();

      drive(2'b00, 0, 2'b00, 1, 0, 32'h1111_0000); settle();
      chk("R2 normal", 64'(mode_o), 64'(2'b00));
      chk("R9 lock set", 64'(lock_o), 64'd1);
      drive(2'b11, 0, 2'b00, 1, 1, 32'h1234_5678); settle();
      chk("R7 pass", 64'(nco_o), 64'h1234_5678);
      drive(2'b01, 0, 2'b00, 1, 0, 32'h0BAD_0BAD); settle();
      chk("R6 captured", 64'(nco_o), 64'h1234_5678);
      chk("R2 hold", 64'(mode_o), 64'(2'b01));

      drive(2'b00, 0, 2'b00, 1, 0, 32'h0); settle();
      drive(2'b11, 0, 2'b00, 1, 1, 32'h2222_3333); settle();
      drive(2'b11, 0, 2'b01, 1, 1, 32'hDEAD_BEEF); settle();
      chk("R3 auto mode", 64'(mode_o), 64'(2'b01));
      chk("R6 frozen", 64'(nco_o), 64'h2222_3333);
      chk("R8 bit4", 64'(stat_o[4]), 64'd1);
      drive(2'b00, 0, 2'b00, 1, 0, 32'h5); settle();
      chk("R4 recovered", 64'(mode_o), 64'(2'b00));

      drive(2'b11, 1, 2'b10, 1, 0, 32'h6); settle();
      chk("R10 switch to bad ref", 64'(mode_o), 64'(2'b01));
      drive(2'b11, 0, 2'b10, 1, 0, 32'h7); settle();
      chk("R4 back on good ref", 64'(mode_o), 64'(2'b00));

      drive(2'b10, 0, 2'b00, 1, 0, 32'h8); settle();
      drive(2'b00, 0, 2'b11, 1, 0, 32'h9); settle();
      chk("R5 refused from free", 64'(mode_o), 64'(2'b10));
      chk("R7 nominal", 64'(nco_o), 64'(NOM));
      drive(2'b01, 0, 2'b11, 1, 0, 32'h9); settle();
      drive(2'b00, 0, 2'b11, 1, 0, 32'h9); settle();
      chk("R5 refused from hold", 64'(mode_o), 64'(2'b01));

      drive(2'b00, 0, 2'b00, 0, 0, 32'hA); settle();
      chk("R9 no lock", 64'(lock_o), 64'd0);
      drive(2'b10, 0, 2'b01, 1, 0, 32'hB); settle();
      chk("R11 free wins", 64'(mode_o), 64'(2'b10));
      drive(2'b00, 0, 2'b00, 1, 0, 32'hC); settle();
      drive(2'b01, 0, 2'b01, 1, 0, 32'hD); settle();
      drive(2'b11, 0, 2'b00, 1, 0, 32'hE); settle();
      chk("R11 manual hold kept", 64'(mode_o), 64'(2'b01));
      drive(2'b00, 0, 2'b00, 1, 0, 32'hF); settle();
      drive(2'b11, 0, 2'b00, 1, 0, 32'h10); settle();
      chk("R2 keep normal", 64'(mode_o), 64'(2'b00));

      for (int n = 0; n < 4000; n++) begin
         logic [1:0] rq;
         int r;
         r = $urandom_range(0, 99);
         rq = (r < 60) ? 2'b11 : (r < 80) ? 2'b00 : (r < 90) ? 2'b01 : 2'b10;
         drive(rq, ($urandom_range(0, 19) == 0) ? ~ref_sel : ref_sel,
               ($urandom_range(0, 7) == 0) ? 2'($urandom) : ref_fail,
               $urandom_range(0, 9) != 0, 1'($urandom), $urandom);
         settle();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule